// File: doc/BRIEF.md
# Transmit Amplifier Level Controller

This block turns a 32-bit transmitter configuration word, a serial transmit-data bit and a synthesizer lock flag into the digital controls of a transmit power amplifier. It produces a 6-bit current-DAC drive code, an amplifier enable and a 2-bit bias-current selection. The modulation mode picks which 6-bit power level in the configuration word reaches the DAC. In the frequency-shift modes one level is used and the data bit has no effect. In amplitude-shift mode the data bit chooses between two levels. In on-off mode it chooses between one level and silence.

The data bit passes through a two-flop synchronizer before use, and an optional polarity inversion applies to it. Two gates override every mode and force the amplifier off with a zero code. One is the stage power-down bit. The other is a mute that holds while the synthesizer is unlocked, if that gate is armed. All outputs are registered on the bit clock and cleared by a synchronous active-high reset.

Top module: `pa_level_ctl`

## Requirements
- R1: While `rst` is high at a clock edge, `dac_code`, `pa_on` and `bias_sel` are all cleared to zero after that edge.
- R2: With mode field `cfg_word[8:6]` equal to 000 (FSK) or 001 (GFSK), and neither gate active, `dac_code` equals `cfg_word[14:9]` and `pa_on` is 1, whatever the level of `tx_data`.
- R3: With mode 010 (ASK) and neither gate active, an active data level gives `dac_code = cfg_word[14:9]` and an inactive level gives `dac_code = cfg_word[20:15]`, with `pa_on` at 1 in both cases.
- R4: With mode 011 (OOK) and neither gate active, an active data level gives `dac_code = cfg_word[14:9]` with `pa_on` = 1, and an inactive level gives `dac_code` = 0 with `pa_on` = 0.
- R5: `cfg_word[29]` sets the data polarity. When it is 0, `tx_data` = 1 is the active level. When it is 1, `tx_data` = 0 is the active level.
- R6: When `cfg_word[4]` is 0 (power-down), `pa_on` = 0 and `dac_code` = 0 in every mode.
- R7: When `cfg_word[5]` is 1 and `pll_locked` is 0, `pa_on` = 0 and `dac_code` = 0. When `cfg_word[5]` is 0, `pll_locked` has no effect on the outputs.
- R8: `bias_sel` equals `cfg_word[31:30]` one cycle later, regardless of mode, mute or power-down.
- R9: Mode values 100 to 111 behave exactly as FSK (R2).
- R10: A change of `cfg_word` or `pll_locked` appears on the outputs after one rising edge. A change of `tx_data` appears after three rising edges: two in the synchronizer and one in the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Transmitter configuration word |
| tx_data | input | 1 | Serial transmit data, asynchronous |
| pll_locked | input | 1 | Synthesizer lock-detect flag |
| dac_code | output | 6 | Amplifier current-DAC drive code |
| pa_on | output | 1 | Amplifier stage enable |
| bias_sel | output | 2 | Amplifier bias-current selection |

## Verification
Several conditions can all call for silence in the same cycle: the lock mute, the power-down bit and an inactive on-off data level. A mode-dependent level choice can also coincide with the lock mute. The bench provokes every such overlap with a sweep over all eight mode codes, both gate bits, lock state, polarity and data level, holding each combination long enough for the synchronized data to settle. Each result is judged against a priority worked out in the bench: the gates win over any mode choice, and the bias field stays unaffected by all of them.

// File: rtl/pa_level_pkg.sv
package pa_level_pkg;

    localparam int CFG_W  = 32;
    localparam int CODE_W = 6;
    localparam int BIAS_W = 2;

    // bit positions a neighbouring loader writes; kept fixed
    localparam int EN_BIT    = 4;
    localparam int GATE_BIT  = 5;
    localparam int MODE_LSB  = 6;
    localparam int HI_LSB    = 9;
    localparam int LO_LSB    = 15;
    localparam int INV_BIT   = 29;
    localparam int BIAS_LSB  = 30;

    typedef enum logic [2:0] {
        MOD_FSK  = 3'b000,
        MOD_GFSK = 3'b001,
        MOD_ASK  = 3'b010,
        MOD_OOK  = 3'b011
    } mod_e;

    typedef struct packed {
        logic [BIAS_W-1:0] bias;
        logic              inv;
        logic [CODE_W-1:0] lvl_lo;
        logic [CODE_W-1:0] lvl_hi;
        mod_e              mode;
        logic              lock_gate;
        logic              stage_en;
    } cfg_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              on;
        logic [BIAS_W-1:0] bias;
    } pa_out_t;

    function automatic mod_e decode_mode(input logic [2:0] raw);
        case (raw)
            3'b001:  return MOD_GFSK;
            3'b010:  return MOD_ASK;
            3'b011:  return MOD_OOK;
            default: return MOD_FSK;
        endcase
    endfunction

    function automatic cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        cfg_t c;
        c.bias      = w[BIAS_LSB +: BIAS_W];
        c.inv       = w[INV_BIT];
        c.lvl_lo    = w[LO_LSB +: CODE_W];
        c.lvl_hi    = w[HI_LSB +: CODE_W];
        c.mode      = decode_mode(w[MODE_LSB +: 3]);
        c.lock_gate = w[GATE_BIT];
        c.stage_en  = w[EN_BIT];
        return c;
    endfunction

endpackage

// File: rtl/pa_data_sync.sv
module pa_data_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_async};
    end

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/pa_level_select.sv
module pa_level_select
    import pa_level_pkg::*;
(
    input  cfg_t    cfg,
    input  logic    data_bit,
    input  logic    locked,
    output pa_out_t nxt
);
    logic active;
    logic gated;

    always_comb begin
        active   = data_bit ^ cfg.inv;
        gated    = !cfg.stage_en || (cfg.lock_gate && !locked);
        nxt.bias = cfg.bias;
        nxt.on   = 1'b1;
        nxt.code = cfg.lvl_hi;
        case (cfg.mode)
            MOD_ASK: nxt.code = active ? cfg.lvl_hi : cfg.lvl_lo;
            MOD_OOK: begin
                nxt.code = active ? cfg.lvl_hi : '0;
                nxt.on   = active;
            end
            default: nxt.code = cfg.lvl_hi;
        endcase
        if (gated) begin
            nxt.code = '0;
            nxt.on   = 1'b0;
        end
    end
endmodule

// File: rtl/pa_out_reg.sv
module pa_out_reg
    import pa_level_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pa_out_t d,
    output pa_out_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/pa_level_ctl.sv
module pa_level_ctl
    import pa_level_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              tx_data,
    input  logic              pll_locked,
    output logic [CODE_W-1:0] dac_code,
    output logic              pa_on,
    output logic [BIAS_W-1:0] bias_sel
);
    cfg_t    cfg;
    logic    data_sync;
    pa_out_t nxt;
    pa_out_t cur;

    assign cfg = unpack_cfg(cfg_word);

    pa_data_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (tx_data),
        .d_sync  (data_sync)
    );

    pa_level_select u_sel (
        .cfg      (cfg),
        .data_bit (data_sync),
        .locked   (pll_locked),
        .nxt      (nxt)
    );

    pa_out_reg u_oreg (
        .clk (clk),
        .rst (rst),
        .d   (nxt),
        .q   (cur)
    );

    assign dac_code = cur.code;
    assign pa_on    = cur.on;
    assign bias_sel = cur.bias;
endmodule

// File: rtl/pa_level_ctl_chk.sv
module pa_level_ctl_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] cfg_word,
    input logic        tx_data,
    input logic        pll_locked,
    input logic        data_sync,
    input logic [5:0]  dac_code,
    input logic        pa_on,
    input logic [1:0]  bias_sel
);
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)            age <= 2'd0;
        else if (age != 3)  age <= age + 2'd1;
    end

    logic open_gate;
    assign open_gate = cfg_word[4] && !(cfg_word[5] && !pll_locked);

    // R8
    bias_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (age != 0) |-> bias_sel == $past(cfg_word[31:30]));

    // R6
    power_down_chk: assert property (@(posedge clk) disable iff (rst)
        (age != 0 && !$past(cfg_word[4])) |-> (!pa_on && dac_code == 6'd0));

    // R7
    lock_mute_chk: assert property (@(posedge clk) disable iff (rst)
        (age != 0 && $past(cfg_word[5] && !pll_locked)) |-> (!pa_on && dac_code == 6'd0));

    // R2
    freq_level_chk: assert property (@(posedge clk) disable iff (rst)
        (age != 0 && $past(open_gate && (cfg_word[8:6] == 3'b000 || cfg_word[8:6] == 3'b001)))
        |-> (pa_on && dac_code == $past(cfg_word[14:9])));

    // R9
    undef_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (age != 0 && $past(open_gate && cfg_word[8]))
        |-> (pa_on && dac_code == $past(cfg_word[14:9])));

    // R3
    ask_on_chk: assert property (@(posedge clk) disable iff (rst)
        (age != 0 && $past(open_gate && cfg_word[8:6] == 3'b010)) |-> pa_on);

    // R4
    ook_off_chk: assert property (@(posedge clk) disable iff (rst)
        (age != 0 && $past(open_gate && cfg_word[8:6] == 3'b011 && !(data_sync ^ cfg_word[29])))
        |-> (!pa_on && dac_code == 6'd0));

    // R10
    sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 3) |-> data_sync == $past(tx_data, 2));
endmodule

bind pa_level_ctl pa_level_ctl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_word   (cfg_word),
    .tx_data    (tx_data),
    .pll_locked (pll_locked),
    .data_sync  (data_sync),
    .dac_code   (dac_code),
    .pa_on      (pa_on),
    .bias_sel   (bias_sel)
);

// File: tb/pa_level_ctl_test.sv
module pa_level_ctl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_word = '0;
    logic        tx_data = 1'b0;
    logic        pll_locked = 1'b0;
    logic [5:0]  dac_code;
    logic        pa_on;
    logic [1:0]  bias_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pa_level_ctl uut (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .tx_data(tx_data),
        .pll_locked(pll_locked), .dac_code(dac_code), .pa_on(pa_on), .bias_sel(bias_sel)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] make_cfg(input int mode, input bit en, input bit gate,
                                             input bit inv, input int hi, input int lo, input int bias);
        return (32'(bias & 3) << 30) | (32'(inv) << 29) | (32'(lo & 63) << 15) |
               (32'(hi & 63) << 9) | (32'(mode & 7) << 6) | (32'(gate) << 5) | (32'(en) << 4);
    endfunction

    // expected {code, on} packed as code*2+on, from requirement text
    function automatic int expect_out(input int mode, input bit en, input bit gate, input bit lock,
                                      input bit inv, input bit d, input int hi, input int lo);
        bit act;
        act = (d != inv);
        if (!en) return 0;                       // R6
        if (gate && !lock) return 0;             // R7
        if (mode == 2) return (act ? hi : lo) * 2 + 1;   // R3
        if (mode == 3) return act ? hi * 2 + 1 : 0;      // R4
        return hi * 2 + 1;                       // R2, R9
    endfunction

    initial begin
        edges(3);
        // R1: reset state
        check("R1 code", dac_code, 0);
        check("R1 on", pa_on, 0);
        check("R1 bias", bias_sel, 0);
        @(negedge clk);
        cfg_word = make_cfg(0, 1, 0, 0, 33, 7, 3);
        rst = 1'b1;
        edges(1);
        check("R1 code held in reset", dac_code, 0);
        check("R1 bias held in reset", bias_sel, 0);
        rst = 1'b0;

        // exhaustive sweep: R2 R3 R4 R5 R6 R7 R8 R9
        for (int idx = 0; idx < 256; idx++) begin
            int mode, hi, lo, bias, e;
            bit en, gate, lock, inv, d;
            mode = idx & 7;
            en   = idx[3]; gate = idx[4]; lock = idx[5]; inv = idx[6]; d = idx[7];
            hi   = 1 + (idx % 62);
            lo   = hi ^ 6'h2A;
            bias = (idx >> 2) & 3;
            cfg_word   = make_cfg(mode, en, gate, inv, hi, lo, bias);
            pll_locked = lock;
            tx_data    = d;
            edges(4);
            e = expect_out(mode, en, gate, lock, inv, d, hi, lo);
            check($sformatf("R2/R3/R4/R5/R6/R7/R9 code idx=%0d", idx), dac_code, e >> 1);
            check($sformatf("R6/R7 on idx=%0d", idx), pa_on, e & 1);
            check($sformatf("R8 bias idx=%0d", idx), bias_sel, bias);
        end

        // R10: data latency of three edges in OOK
        cfg_word = make_cfg(3, 1, 0, 0, 45, 9, 1);
        pll_locked = 1'b1;
        tx_data = 1'b0;
        edges(4);
        check("R10 settle off", dac_code, 0);
        tx_data = 1'b1;
        edges(2);
        check("R10 not yet after two edges", dac_code, 0);
        edges(1);
        check("R10 code after three edges", dac_code, 45);
        check("R10 on after three edges", pa_on, 1);

        // R10: config latency of one edge
        cfg_word = make_cfg(3, 1, 0, 0, 12, 9, 2);
        edges(1);
        check("R10 cfg one edge code", dac_code, 12);
        check("R10 cfg one edge bias", bias_sel, 2);

        // R7: lock ignored when gate clear, and lock drop mutes in one edge when set
        pll_locked = 1'b0;
        edges(1);
        check("R7 lock ignored", dac_code, 12);
        cfg_word = make_cfg(3, 1, 1, 0, 12, 9, 2);
        edges(1);
        check("R7 muted one edge", pa_on, 0);
        check("R8 bias kept while muted", bias_sel, 2);
        pll_locked = 1'b1;
        edges(1);
        check("R7 unmuted on lock", dac_code, 12);

        // R5: inverted polarity in ASK flips level within three edges
        cfg_word = make_cfg(2, 1, 0, 1, 50, 20, 0);
        tx_data = 1'b1;
        edges(4);
        check("R5 inverted high is inactive", dac_code, 20);
        tx_data = 1'b0;
        edges(3);
        check("R5 inverted low is active", dac_code, 50);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule